// File: doc/BRIEF.md
# Universal Bidirectional Bus Transceiver

This block moves an 18-bit word between two ports, called A and B, in either direction. Each direction has three controls of its own: an output enable, a latch enable and a direction clock. Each direction also has one storage element per bit. This element can pass data straight through, hold it, or capture it on a rising edge of the direction clock. A path therefore runs in one of three modes: transparent, latched or clocked. The block samples the direction clocks with the system clock `clk` and turns a low-to-high change between two samples into a capture.

The tri-state pins are modelled as separate signals. Each port has an output data vector and one output-enable bit, so the block stays synthesizable, and the bidirectional wires are resolved outside it. The external drive on each port arrives as a data vector plus a per-bit mask that says which bits are driven. A bus-hold stage keeps every undriven bit at the last level that was driven onto it from outside. An active-low asynchronous reset clears both storage elements and both bus-hold registers to zero.

Top module: `ubt_transceiver`

## Requirements
- R1: While `ab_le` is 1, `b_out` equals the effective A input in the same cycle (transparent mode).
- R2: While `ab_le` is 0, a rise of `ab_ck` (0 at the previous `clk` edge, 1 at this one) stores the effective A input, and `b_out` shows that value from the next cycle on.
- R3: While `ab_le` is 0 and `ab_ck` does not rise, `b_out` keeps its value whatever the A input does.
- R4: When `ab_le` falls while `ab_ck` is high, `b_out` keeps the last value that passed through before the fall, until the next rise of `ab_ck`.
- R5: `b_oe` is 1 exactly when `ab_oe` is 1 (active-high enable).
- R6: `a_oe` is 1 exactly when `ba_oe_n` is 0 (active-low enable).
- R7: The B-to-A path behaves like the A-to-B path, using `ba_le` and `ba_ck`, from the effective B input to `a_out`.
- R8: A bit whose drive mask bit (`a_drv` or `b_drv`) is 0 reads as the last level that was driven onto it from outside.
- R9: While `rst_n` is low, and after it until the first capture, both storage elements and both bus-hold registers hold 0, so an output in latched mode reads 0.
- R10: A capture in one direction leaves the stored value of the other direction unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the controls and updates the storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Level driven onto port A from outside |
| a_drv | input | 18 | Per-bit mask of the A bits driven from outside (1 = driven) |
| b_in | input | 18 | Level driven onto port B from outside |
| b_drv | input | 18 | Per-bit mask of the B bits driven from outside (1 = driven) |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_ck | input | 1 | A-to-B direction clock, captures on a rise |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_ck | input | 1 | B-to-A direction clock, captures on a rise |
| a_out | output | 18 | Data this block drives onto port A |
| a_oe | output | 1 | Port A is driven by this block when 1, high impedance when 0 |
| b_out | output | 18 | Data this block drives onto port B |
| b_oe | output | 1 | Port B is driven by this block when 1, high impedance when 0 |

## Verification
A rising direction clock and a change of the latch enable can land in the same system cycle. The hardest case is the latch enable falling while the direction clock is already high. The bench provokes this by lowering `ab_le` in a cycle where `ab_ck` stays high, and it changes the A data at the same moment. It then expects `b_out` to hold the value from before the fall, and to move only after a later low-to-high change of `ab_ck`. A capture and a bus-hold update also happen on the same edge. The bench judges this by releasing A bits in the cycle after a transparent pass and checking that those bits keep their old level.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

   // Control bundle of one direction: enable, latch enable, direction clock
   typedef struct packed {
      logic oe;
      logic le;
      logic ck;
   } ubt_ctl_t;

endpackage

// File: rtl/ubt_bus_hold.sv
module ubt_bus_hold #(
   parameter int WIDTH   = 18,
   parameter bit HOLD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] in_i,
   input  logic [WIDTH-1:0] drv_i,
   output logic [WIDTH-1:0] x_o
);

   localparam logic [WIDTH-1:0] ZERO = '0;

   if (WIDTH < 1) begin : g_bad_width
      $error("ubt_bus_hold: WIDTH must be at least 1");
   end

   if (HOLD_EN) begin : g_hold
      logic [WIDTH-1:0] hold_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hold_q <= ZERO;
         else        hold_q <= x_o;
      end

      assign x_o = (drv_i & in_i) | (~drv_i & hold_q);

      for (genvar k = 0; k < WIDTH; k++) begin : g_chk
         // R8: a bit released after being driven keeps the driven level
         p_keep_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
            drv_i[k] ##1 !drv_i[k] |-> x_o[k] == $past(in_i[k]));
      end
   end else begin : g_nohold
      assign x_o = drv_i & in_i;
   end

endmodule

// File: rtl/ubt_path.sv
module ubt_path
   import ubt_pkg::*;
#(
   parameter int WIDTH         = 18,
   parameter bit OE_ACTIVE_LOW = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ubt_ctl_t         ctl_i,
   input  logic [WIDTH-1:0] x_i,
   output logic [WIDTH-1:0] y_o,
   output logic             en_o
);

   localparam logic [WIDTH-1:0] ZERO = '0;

   if (WIDTH < 1) begin : g_bad_width
      $error("ubt_path: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] store_q;
   logic             ck_q;
   logic             ck_rise;

   assign ck_rise = ctl_i.ck & ~ck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q <= ZERO;
         ck_q    <= 1'b0;
      end else begin
         ck_q <= ctl_i.ck;
         if (ctl_i.le || ck_rise) store_q <= x_i;
      end
   end

   assign y_o = ctl_i.le ? x_i : store_q;

   if (OE_ACTIVE_LOW) begin : g_oe_low
      assign en_o = ~ctl_i.oe;
   end else begin : g_oe_high
      assign en_o = ctl_i.oe;
   end

   // R1: transparent mode passes the input through in the same cycle
   p_transparent_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_i.le |-> y_o == x_i);

   // R2: a clock rise with the latch closed shows the input one cycle later
   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_i.le && ctl_i.ck && !ck_q) ##1 !ctl_i.le |-> y_o == $past(x_i));

   // R3: latch closed and clock held low keeps the output steady
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_i.le && !ctl_i.ck) ##1 (!ctl_i.le && !ctl_i.ck) |-> $stable(y_o));

   // R4: closing the latch while the clock is high keeps the passed value
   p_latch_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_i.le && ctl_i.ck) ##1 (!ctl_i.le && ctl_i.ck) |-> y_o == $past(x_i));

endmodule

// File: rtl/ubt_transceiver.sv
module ubt_transceiver
   import ubt_pkg::*;
#(
   parameter int WIDTH   = 18,
   parameter bit HOLD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] a_drv,
   input  logic [WIDTH-1:0] b_in,
   input  logic [WIDTH-1:0] b_drv,
   input  logic             ab_oe,
   input  logic             ab_le,
   input  logic             ab_ck,
   input  logic             ba_oe_n,
   input  logic             ba_le,
   input  logic             ba_ck,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe
);

   logic [WIDTH-1:0] a_eff;
   logic [WIDTH-1:0] b_eff;
   ubt_ctl_t         ctl_ab;
   ubt_ctl_t         ctl_ba;

   assign ctl_ab = '{oe: ab_oe,   le: ab_le, ck: ab_ck};
   assign ctl_ba = '{oe: ba_oe_n, le: ba_le, ck: ba_ck};

   ubt_bus_hold #(.WIDTH(WIDTH), .HOLD_EN(HOLD_EN)) u_hold_a (
      .clk(clk), .rst_n(rst_n), .in_i(a_in), .drv_i(a_drv), .x_o(a_eff));

   ubt_bus_hold #(.WIDTH(WIDTH), .HOLD_EN(HOLD_EN)) u_hold_b (
      .clk(clk), .rst_n(rst_n), .in_i(b_in), .drv_i(b_drv), .x_o(b_eff));

   ubt_path #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b0)) u_path_ab (
      .clk(clk), .rst_n(rst_n), .ctl_i(ctl_ab), .x_i(a_eff),
      .y_o(b_out), .en_o(b_oe));

   ubt_path #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b1)) u_path_ba (
      .clk(clk), .rst_n(rst_n), .ctl_i(ctl_ba), .x_i(b_eff),
      .y_o(a_out), .en_o(a_oe));

endmodule

// File: tb/ubt_transceiver_tb.sv
`timescale 1ns/1ps
module ubt_transceiver_tb;

   localparam int W = 18;

   typedef struct {
      string        tag;
      int           sel;
      logic [W-1:0] exp;
   } item_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_in = '0, a_drv = '0, b_in = '0, b_drv = '0;
   logic         ab_oe = 1'b0, ab_le = 1'b0, ab_ck = 1'b0;
   logic         ba_oe_n = 1'b1, ba_le = 1'b0, ba_ck = 1'b0;
   logic [W-1:0] a_out, b_out;
   logic         a_oe, b_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   item_t q[$];

   // reference state, updated from the requirements
   logic [W-1:0] m_ab, m_ba, m_ha, m_hb;
   logic         m_cka, m_ckb;

   always #4 clk = ~clk;

   ubt_transceiver #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_drv(a_drv), .b_in(b_in),
      .b_drv(b_drv), .ab_oe(ab_oe), .ab_le(ab_le), .ab_ck(ab_ck),
      .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_ck(ba_ck), .a_out(a_out),
      .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));

   function automatic logic [W-1:0] eff(input logic [W-1:0] v,
                                        input logic [W-1:0] d,
                                        input logic [W-1:0] h);
      return (d & v) | (~d & h);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ab <= '0; m_ba <= '0; m_ha <= '0; m_hb <= '0;
         m_cka <= 1'b0; m_ckb <= 1'b0;
      end else begin
         m_ha <= eff(a_in, a_drv, m_ha);
         m_hb <= eff(b_in, b_drv, m_hb);
         if (ab_le || (ab_ck && !m_cka)) m_ab <= eff(a_in, a_drv, m_ha);
         if (ba_le || (ba_ck && !m_ckb)) m_ba <= eff(b_in, b_drv, m_hb);
         m_cka <= ab_ck;
         m_ckb <= ba_ck;
      end
   end

   task automatic drive(input logic [W-1:0] a, input logic [W-1:0] ad,
                        input logic [W-1:0] b, input logic [W-1:0] bd,
                        input logic oeab, input logic leab, input logic ckab,
                        input logic oeba_n, input logic leba, input logic ckba,
                        input string rb, input string ra);
      logic [W-1:0] ea, eb;
      @(negedge clk);
      a_in = a; a_drv = ad; b_in = b; b_drv = bd;
      ab_oe = oeab; ab_le = leab; ab_ck = ckab;
      ba_oe_n = oeba_n; ba_le = leba; ba_ck = ckba;
      ea = eff(a, ad, m_ha);
      eb = eff(b, bd, m_hb);
      q.push_back('{rb, 0, leab ? ea : m_ab});
      q.push_back('{"R5", 2, {{(W-1){1'b0}}, oeab}});
      q.push_back('{ra, 1, leba ? eb : m_ba});
      q.push_back('{"R6", 3, {{(W-1){1'b0}}, ~oeba_n}});
   endtask

   // monitor: compares expectations away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         #3;
         while (q.size() > 0) begin
            item_t it;
            logic [W-1:0] act;
            it = q.pop_front();
            case (it.sel)
               0: act = b_out;
               1: act = a_out;
               2: act = {{(W-1){1'b0}}, b_oe};
               default: act = {{(W-1){1'b0}}, a_oe};
            endcase
            checks++;
            if (act !== it.exp) begin
               fails++;
               $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag,
                        it.sel, act, it.exp);
            end
         end
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   localparam logic [W-1:0] ALL = '1;
   localparam logic [W-1:0] NONE = '0;

   initial begin
      // R9: reset state, latched mode reads zero
      for (int i = 0; i < 3; i++)
         drive(18'h3FFFF, ALL, 18'h2AAAA, ALL, 0, 0, 0, 1, 0, 0, "R9", "R9");
      @(negedge clk);
      rst_n = 1'b1;
      drive(18'h1F00F, ALL, 18'h3000C, ALL, 0, 0, 0, 1, 0, 0, "R9", "R9");

      // R1: transparent A to B under several patterns, B driven from here
      drive(18'h15555, ALL, 18'h0, NONE, 1, 1, 0, 1, 0, 0, "R1", "R10");
      drive(18'h2AAAA, ALL, 18'h0, NONE, 1, 1, 0, 1, 0, 0, "R1", "R10");
      drive(18'h00001, ALL, 18'h0, NONE, 1, 1, 0, 1, 0, 0, "R1", "R10");
      drive(18'h12345, ALL, 18'h0, NONE, 1, 1, 1, 1, 0, 0, "R1", "R10");

      // R4: latch enable falls while the direction clock is high
      drive(18'h0F0F0, ALL, 18'h0, NONE, 1, 0, 1, 1, 0, 0, "R4", "R10");
      drive(18'h3C3C3, ALL, 18'h0, NONE, 1, 0, 1, 1, 0, 0, "R4", "R10");
      // R3: clock held low, data moves, output holds
      drive(18'h11111, ALL, 18'h0, NONE, 1, 0, 0, 1, 0, 0, "R3", "R10");
      drive(18'h22222, ALL, 18'h0, NONE, 1, 0, 0, 1, 0, 0, "R3", "R10");
      // R2: rise captures, visible from the next cycle
      drive(18'h2BEEF, ALL, 18'h0, NONE, 1, 0, 1, 1, 0, 0, "R2", "R10");
      drive(18'h00F00, ALL, 18'h0, NONE, 1, 0, 1, 1, 0, 0, "R2", "R10");
      drive(18'h3FFFF, ALL, 18'h0, NONE, 1, 0, 0, 1, 0, 0, "R3", "R10");
      // R5: disable A-to-B
      drive(18'h3FFFF, ALL, 18'h0, NONE, 0, 0, 0, 1, 0, 0, "R5", "R10");

      // R7: B to A, active-low enable on, A driven by the block
      drive(18'h0, NONE, 18'h0ABCD, ALL, 0, 0, 0, 0, 1, 0, "R10", "R7");
      drive(18'h0, NONE, 18'h31234, ALL, 0, 0, 0, 0, 0, 1, "R10", "R7");
      drive(18'h0, NONE, 18'h05A5A, ALL, 0, 0, 0, 0, 0, 0, "R10", "R7");
      drive(18'h0, NONE, 18'h1C0DE, ALL, 0, 0, 0, 0, 0, 1, "R10", "R7");
      drive(18'h0, NONE, 18'h00000, ALL, 0, 0, 0, 0, 0, 1, "R10", "R7");
      // R10: A-to-B capture must not touch the B-to-A store
      drive(18'h0, NONE, 18'h3F3F3, ALL, 0, 0, 1, 0, 0, 1, "R10", "R10");
      drive(18'h0, NONE, 18'h3F3F3, ALL, 0, 0, 0, 0, 0, 0, "R2", "R10");

      // R8: bus hold on A through a transparent A-to-B path
      drive(18'h3FFFF, ALL, 18'h0, NONE, 1, 1, 0, 1, 0, 0, "R8", "R10");
      drive(18'h00000, 18'h000FF, 18'h0, NONE, 1, 1, 0, 1, 0, 0, "R8", "R10");
      drive(18'h00000, NONE, 18'h0, NONE, 1, 1, 0, 1, 0, 0, "R8", "R10");
      drive(18'h2AAAA, 18'h3FF00, 18'h0, NONE, 1, 1, 0, 1, 0, 0, "R8", "R10");
      // R8: bus hold on B through a transparent B-to-A path
      drive(18'h0, NONE, 18'h15555, ALL, 0, 0, 0, 0, 1, 0, "R10", "R8");
      drive(18'h0, NONE, 18'h00000, 18'h0000F, 0, 0, 0, 0, 1, 0, "R10", "R8");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule